// File: doc/BRIEF.md
# Burst Address Counter with Repeat

This block produces the address used by one port of a synchronous static memory. In each clock cycle it presents one of three addresses to the array. It can pass through the address on the pins. It can use an internal counter that moves forward by one per clock or stays put. It can return to the start address that was loaded most recently. A shadow register keeps that start address, so a return costs no idle cycle. A read or a write can happen in the same cycle as the return, at the restored location.

The counter covers only the low address bits. The most significant bit is always taken straight from the external address and chooses the lower or upper half of the array. Any rollover of the counter therefore stays inside the current half. The block includes a small behavioural memory. Its read data comes out either one cycle after the access (flow-through) or two cycles after it (pipelined), chosen by a parameter.

Control is written as four named commands, decoded each cycle from three active-low strobes, with repeat taking priority over load and load over advance:

- HOLD: no strobe is active, and the counter keeps its value.
- LOAD: the counter and the shadow take the external low bits.
- ADVANCE: the counter adds one.
- REPEAT: the counter takes the shadow value.

Every command returns to the same decision in the next cycle. The counter register always keeps the address of the access just made.

Top module: `burst_addr_port`

## Requirements
- R1: After reset the counter and the shadow start address are both zero. An idle cycle presents low address 0, and a repeat presents low address 0.
- R2: When `load_n` is 0 and `rpt_n` is 1, `int_addr` equals `ext_addr` in that same cycle.
- R3: When `adv_n` is 0 and neither `load_n` nor `rpt_n` is 0, the low bits of `int_addr` are the previous cycle's low bits plus one.
- R4: When all three strobes are 1, the low bits of `int_addr` repeat the previous cycle's low bits.
- R5: When `rpt_n` is 0, the low bits of `int_addr` equal the low bits captured by the most recent load. Advance and repeat cycles never change this saved value.
- R6: Priority is repeat, then load, then advance, then hold. Load with advance presents the external address, and repeat with load presents the saved start address.
- R7: The low counter field is 19 bits wide. Advancing from 0x7FFFF gives 0x00000, and bit 19 of `int_addr` does not change.
- R8: Bit 19 of `int_addr` always equals bit 19 of `ext_addr`, whatever the command.
- R9: In a repeat cycle a write (`wr_en` 1) stores at the restored address, and a read returns the restored address's contents, with no idle cycle. The memory array is indexed by bit 19 and the low 5 address bits.
- R10: With `PIPE_RD` = 0, data read in a cycle appears on `rd_data` after the clock edge that ends that cycle.
- R11: With `PIPE_RD` = 1, read data appears one clock later than with `PIPE_RD` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_addr | input | 20 | External address; bit 19 selects the array half |
| load_n | input | 1 | Active-low load of the counter and the shadow |
| adv_n | input | 1 | Active-low count advance |
| rpt_n | input | 1 | Active-low return to the saved start address |
| wr_en | input | 1 | Write strobe for the current address |
| wr_data | input | 36 | Write data |
| rd_data | output | 36 | Read data, after one or two cycles |
| int_addr | output | 20 | Address presented to the array |

## Verification
The hardest case to reach is a repeat that must find the right start address after the counter has moved away from it. A second load must also have been blocked by the higher-priority repeat. The stimulus loads a start address, advances and writes distinct data, and then asserts repeat and load together with a different external address. The saved address must win, and the read in that cycle must return the first word written. A second DUT with pipelined reads runs on the same inputs, so the one-cycle difference in latency is checked on identical traffic.

// File: rtl/burst_pkg.sv
package burst_pkg;
    typedef enum logic [1:0] {
        CMD_HOLD    = 2'd0,
        CMD_LOAD    = 2'd1,
        CMD_ADVANCE = 2'd2,
        CMD_REPEAT  = 2'd3
    } burst_cmd_e;
endpackage

// File: rtl/burst_cmd_dec.sv
module burst_cmd_dec
    import burst_pkg::*;
(
    input  logic       load_n,
    input  logic       adv_n,
    input  logic       rpt_n,
    output burst_cmd_e cmd
);
    // Fixed priority: repeat over load over advance; hold otherwise.
    always_comb begin
        if (!rpt_n)       cmd = CMD_REPEAT;
        else if (!load_n) cmd = CMD_LOAD;
        else if (!adv_n)  cmd = CMD_ADVANCE;
        else              cmd = CMD_HOLD;
    end
endmodule

// File: rtl/burst_addr_ctr.sv
module burst_addr_ctr
    import burst_pkg::*;
#(
    parameter int CW = 19
) (
    input  logic          clk,
    input  logic          rst_n,
    input  burst_cmd_e    cmd,
    input  logic [CW-1:0] ext_low,
    output logic [CW-1:0] cur_low
);
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] start_q;

    // Output decision: the address used by the access in this cycle.
    always_comb begin
        cur_low = cnt_q;
        unique case (cmd)
            CMD_REPEAT:  cur_low = start_q;
            CMD_LOAD:    cur_low = ext_low;
            CMD_ADVANCE: cur_low = cnt_q + CW'(1);
            CMD_HOLD:    cur_low = cnt_q;
        endcase
    end

    // State register: the counter keeps the last used address, the shadow
    // keeps the last loaded one.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            start_q <= '0;
        end else begin
            cnt_q <= cur_low;
            if (cmd == CMD_LOAD) start_q <= ext_low;
        end
    end

    assert_advance_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_ADVANCE) |=> (cnt_q == CW'($past(cnt_q) + CW'(1))));

    assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_HOLD) |=> (cnt_q == $past(cnt_q)));

    assert_shadow_keep_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd != CMD_LOAD) |=> $stable(start_q));

    assert_repeat_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_REPEAT) |=> (cnt_q == $past(start_q)));
endmodule

// File: rtl/burst_ram.sv
module burst_ram #(
    parameter int DW      = 36,
    parameter int IW      = 6,
    parameter bit PIPE_RD = 1'b0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [IW-1:0] idx,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    output logic [DW-1:0] rd_data
);
    localparam int DEPTH = 1 << IW;

    logic [DW-1:0] mem [DEPTH];
    logic [DW-1:0] rd_s1;

    always_ff @(posedge clk) begin
        if (wr_en) mem[idx] <= wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_s1 <= '0;
        else        rd_s1 <= mem[idx];
    end

    generate
        if (PIPE_RD) begin : g_pipe
            logic [DW-1:0] rd_s2;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) rd_s2 <= '0;
                else        rd_s2 <= rd_s1;
            end
            assign rd_data = rd_s2;
        end else begin : g_flow
            assign rd_data = rd_s1;
        end
    endgenerate
endmodule

// File: rtl/burst_addr_port.sv
module burst_addr_port
    import burst_pkg::*;
#(
    parameter int CW      = 19,
    parameter int DW      = 36,
    parameter int RAM_LOW = 5,
    parameter bit PIPE_RD = 1'b0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW:0]   ext_addr,
    input  logic          load_n,
    input  logic          adv_n,
    input  logic          rpt_n,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    output logic [DW-1:0] rd_data,
    output logic [CW:0]   int_addr
);
    localparam int AW = CW + 1;
    localparam int IW = RAM_LOW + 1;

    burst_cmd_e    cmd;
    logic [CW-1:0] cur_low;
    logic [IW-1:0] ram_idx;

    burst_cmd_dec u_dec (
        .load_n (load_n),
        .adv_n  (adv_n),
        .rpt_n  (rpt_n),
        .cmd    (cmd)
    );

    burst_addr_ctr #(.CW(CW)) u_ctr (
        .clk     (clk),
        .rst_n   (rst_n),
        .cmd     (cmd),
        .ext_low (ext_addr[CW-1:0]),
        .cur_low (cur_low)
    );

    // The half-select bit bypasses the counter.
    assign int_addr = {ext_addr[AW-1], cur_low};
    assign ram_idx  = {int_addr[AW-1], int_addr[RAM_LOW-1:0]};

    burst_ram #(.DW(DW), .IW(IW), .PIPE_RD(PIPE_RD)) u_ram (
        .clk     (clk),
        .rst_n   (rst_n),
        .idx     (ram_idx),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .rd_data (rd_data)
    );

    assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_n && rpt_n) |-> (int_addr == ext_addr));
endmodule

// File: tb/burst_addr_port_tb.sv
module burst_addr_port_tb;
    localparam int CLK_PERIOD = 10;
    localparam int CW = 19;
    localparam int DW = 36;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [CW:0]   ext_addr = '0;
    logic          load_n = 1'b1, adv_n = 1'b1, rpt_n = 1'b1, wr_en = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic [DW-1:0] rd_flow, rd_pipe;
    logic [CW:0]   addr_flow, addr_pipe;

    int n_checks = 0;
    int n_fail = 0;

    logic [CW-1:0] m_cnt = '0;
    logic [CW-1:0] m_start = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    burst_addr_port #(.PIPE_RD(1'b0)) u_dut (
        .clk(clk), .rst_n(rst_n), .ext_addr(ext_addr), .load_n(load_n),
        .adv_n(adv_n), .rpt_n(rpt_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_flow), .int_addr(addr_flow));

    burst_addr_port #(.PIPE_RD(1'b1)) u_dut_pipe (
        .clk(clk), .rst_n(rst_n), .ext_addr(ext_addr), .load_n(load_n),
        .adv_n(adv_n), .rpt_n(rpt_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_pipe), .int_addr(addr_pipe));

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // One cycle: drive at the falling edge, check the address, update the model.
    task automatic cyc(input logic ld, input logic adv, input logic rpt,
                       input logic [CW:0] ext, input logic we,
                       input logic [DW-1:0] wd, input string tag);
        logic [CW-1:0] exp_low;
        @(negedge clk);
        load_n = ld; adv_n = adv; rpt_n = rpt; ext_addr = ext;
        wr_en = we; wr_data = wd;
        #1;
        if (!rpt)      exp_low = m_start;
        else if (!ld)  exp_low = ext[CW-1:0];
        else if (!adv) exp_low = m_cnt + 1'b1;
        else           exp_low = m_cnt;
        chk(tag, 64'(addr_flow), 64'({ext[CW], exp_low}));
        chk({tag, " pipe-port"}, 64'(addr_pipe), 64'({ext[CW], exp_low}));
        m_cnt = exp_low;
        if (rpt && !ld) m_start = ext[CW-1:0];
    endtask

    task automatic t_reset;
        cyc(1, 1, 1, 20'h00000, 0, '0, "R1 idle after reset");
        cyc(1, 1, 0, 20'h00000, 0, '0, "R1 repeat after reset");
        chk("R1 low bits zero", 64'(addr_flow[CW-1:0]), 64'h0);
    endtask

    task automatic t_load;
        cyc(0, 0, 1, 20'h92345, 0, '0, "R2 R6 load beats advance");
        chk("R2 same-cycle load", 64'(addr_flow), 64'h92345);
    endtask

    task automatic t_advance;
        cyc(1, 0, 1, 20'h80000, 0, '0, "R3 advance 1");
        chk("R3 step", 64'(addr_flow), 64'h92346);
        cyc(1, 0, 1, 20'h0ABCD, 0, '0, "R3 R8 advance with top 0");
        chk("R8 top follows pin", 64'(addr_flow[CW]), 64'h0);
        cyc(1, 0, 1, 20'h80000, 0, '0, "R3 advance 3");
    endtask

    task automatic t_hold;
        cyc(1, 1, 1, 20'h81111, 0, '0, "R4 hold 1");
        cyc(1, 1, 1, 20'h02222, 0, '0, "R4 R8 hold 2");
        chk("R4 held value", 64'(addr_flow), 64'h12348);
    endtask

    task automatic t_repeat;
        cyc(1, 1, 0, 20'h80000, 0, '0, "R5 repeat to start");
        chk("R5 start address", 64'(addr_flow), 64'h92345);
        cyc(0, 1, 0, 20'h85555, 0, '0, "R6 repeat beats load");
        chk("R6 shadow not reloaded", 64'(addr_flow), 64'h92345);
        cyc(1, 0, 1, 20'h80000, 0, '0, "R3 advance after repeat");
        cyc(1, 1, 0, 20'h00000, 0, '0, "R5 R8 shadow kept after advance");
        chk("R5 second repeat", 64'(addr_flow), 64'h12345);
    endtask

    task automatic t_wrap;
        cyc(0, 1, 1, 20'h7FFFE, 0, '0, "R2 load near top");
        cyc(1, 0, 1, 20'h00000, 0, '0, "R7 to 7FFFF");
        cyc(1, 0, 1, 20'h00000, 0, '0, "R7 wrap low half");
        chk("R7 wrapped to zero", 64'(addr_flow), 64'h00000);
        cyc(0, 1, 1, 20'hFFFFF, 0, '0, "R2 load upper top");
        cyc(1, 0, 1, 20'h80000, 0, '0, "R7 wrap upper half");
        chk("R7 top bit kept", 64'(addr_flow), 64'h80000);
    endtask

    task automatic t_ram;
        cyc(0, 1, 1, 20'h00004, 1, 36'hA0A0A0A00, "R9 load and write D0");
        cyc(1, 0, 1, 20'h00000, 1, 36'hB1B1B1B11, "R9 advance write D1");
        cyc(1, 0, 1, 20'h00000, 1, 36'hC2C2C2C22, "R9 advance write D2");
        cyc(1, 1, 0, 20'h00000, 0, '0, "R9 repeat read");
        cyc(1, 0, 1, 20'h00000, 0, '0, "R9 advance read");
        chk("R9 R10 read in repeat cycle", 64'(rd_flow), 64'h0A0A0A0A00);
        cyc(1, 1, 0, 20'h00000, 1, 36'hD3D3D3D33, "R9 repeat with write");
        chk("R10 flow read next", 64'(rd_flow), 64'h0B1B1B1B11);
        chk("R11 pipe one cycle later", 64'(rd_pipe), 64'h0A0A0A0A00);
        cyc(1, 1, 1, 20'h00000, 0, '0, "R4 hold read");
        chk("R10 old data in write cycle", 64'(rd_flow), 64'h0A0A0A0A00);
        chk("R11 pipe second word", 64'(rd_pipe), 64'h0B1B1B1B11);
        cyc(1, 1, 1, 20'h00000, 0, '0, "R4 hold");
        chk("R9 write landed at restored addr", 64'(rd_flow), 64'h0D3D3D3D33);
        cyc(1, 1, 1, 20'h00000, 0, '0, "R4 hold");
        chk("R11 pipe write landed", 64'(rd_pipe), 64'h0D3D3D3D33);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R1 reset address", 64'(addr_flow), 64'h0);
        chk("R1 reset read data", 64'(rd_flow), 64'h0);
        t_reset();
        t_load();
        t_advance();
        t_hold();
        t_repeat();
        t_wrap();
        t_ram();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule